// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block sits next to a NAND data register. It forms a 24-bit Hamming-style code for every 256-byte chunk of a page. While the mode field says accumulate, each byte that crosses the data register in either direction folds into a running line parity and a running column parity. When the 256th byte of a chunk arrives, the finished code is stored in the next slot and the running parity starts again from zero. Software later reads the codes back through the data-register read path and compares them with the codes it stored on the flash. Error correction is done in software.

A page starts with the sequence clear, off, accumulate. Readout uses the sequence off, readout. Each data-register read strobe in readout mode then steps to the next stored byte. The bytes come out three per chunk, chunk by chunk, in a fixed order within each chunk. Slots that were never written read as erased.

Top module: `nand_ecc_acc`

## Requirements
- R1: `ecc_mode_i` encodes 2'b00 off, 2'b01 accumulate, 2'b10 readout and 2'b11 clear. Outside readout mode, `ecc_byte_o` is 8'h00.
- R2: Clear mode sets every slot to 24'hFFFFFF and zeroes the chunk slot index and the byte-in-chunk counter. Any partly accumulated chunk is discarded.
- R3: Only transfers (`xfer_valid_i` high) made while the mode is accumulate change the accumulated state. Transfers in off or readout mode are ignored.
- R4: Each transfer in accumulate mode takes the next byte address, 0 to 255. After the transfer at address 255, the finished code goes into the current slot, the slot index advances, and a new chunk begins. A chunk that is only partly filled leaves its slot unchanged.
- R5: Code byte 0 bit i and code byte 1 bit i hold the inverted line parities. Line parity 2k+1 is the XOR of all data bits in bytes whose address bit k is 1. Line parity 2k uses the bytes whose address bit k is 0. Byte 0 bits 7..0 are LP7..LP0 and byte 1 bits 7..0 are LP15..LP8.
- R6: Code byte 2 holds the inverted column parities in bits 7..2, as CP5..CP0, and bits 1:0 read 1. The data bits used are: CP0 = bits 0,2,4,6; CP1 = bits 1,3,5,7; CP2 = bits 0,1,4,5; CP3 = bits 2,3,6,7; CP4 = bits 0..3; CP5 = bits 4..7. Each is taken over all 256 bytes.
- R7: All stored code bits are inverted, so a chunk of 256 bytes of 8'hFF yields the code FF FF FF.
- R8: On entering readout mode the sequence restarts at chunk 0. Each `rd_strobe_i` in readout mode advances one position. Within a chunk the order is code byte 1, then byte 0, then byte 2, and chunks follow in slot order.
- R9: After 3×NUM_CHUNKS bytes have been read, `ecc_byte_o` stays 8'hFF and further strobes do not move the position.
- R10: Once all NUM_CHUNKS slots are written, further accumulate transfers are ignored until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_mode_i | input | 2 | ECC mode field |
| xfer_valid_i | input | 1 | A data byte crosses the data register this cycle |
| xfer_data_i | input | 8 | The byte crossing the data register |
| rd_strobe_i | input | 1 | Data-register read, used as the step signal in readout mode |
| ecc_byte_o | output | 8 | Current ECC readout byte |

## Verification
The bench computes expected codes from R5 and R6 and compares them with the design's output for several kinds of chunk:
- An erased chunk of all 8'hFF tells the inversion apart from raw parity.
- Chunks with a single set bit at a chosen address and bit position each excite exactly one parity of every pair. These expose a swapped line-parity pair, a wrong column grouping or a wrong readout order.
- Random chunks cover the general mix.

The bench also checks these cases:
- Bytes sent in off and readout modes, plus a discarded partial chunk, show whether the byte counter or the slot index moved when it should not have.
- Nine chunks with only eight slots, and readout past the last slot, cover the saturation rules.
- Re-entering readout shows whether the sequence restarts at chunk 0.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_OFF   = 2'b00,
        ECC_ACC   = 2'b01,
        ECC_READ  = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    localparam int ADDR_W = 8;
    localparam int LP_W   = 2 * ADDR_W;
    localparam int CODE_W = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic [LP_W-1:0]   lp;
        logic [7:0]        col;
    } acc_s;

    // column parity terms {CP5..CP0, 2'b00} of an XOR-folded byte
    function automatic logic [7:0] col_terms(input logic [7:0] x);
        logic [5:0] cp;
        cp[0] = x[0] ^ x[2] ^ x[4] ^ x[6];
        cp[1] = x[1] ^ x[3] ^ x[5] ^ x[7];
        cp[2] = x[0] ^ x[1] ^ x[4] ^ x[5];
        cp[3] = x[2] ^ x[3] ^ x[6] ^ x[7];
        cp[4] = ^x[3:0];
        cp[5] = ^x[7:4];
        return {cp, 2'b00};
    endfunction

endpackage

// File: rtl/nand_ecc_chunk.sv
module nand_ecc_chunk
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [7:0]        data_i,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    acc_s st_d, st_q;
    logic [LP_W-1:0] lp_upd;
    logic [7:0]      col_upd;
    logic            par;

    always_comb begin
        st_d    = st_q;
        done_o  = 1'b0;
        par     = ^data_i;
        col_upd = st_q.col ^ data_i;
        lp_upd  = st_q.lp;
        for (int k = 0; k < ADDR_W; k++) begin
            lp_upd[2*k+1] = lp_upd[2*k+1] ^ (par & st_q.cnt[k]);
            lp_upd[2*k]   = lp_upd[2*k]   ^ (par & ~st_q.cnt[k]);
        end
        code_o = {~col_terms(col_upd), ~lp_upd[15:8], ~lp_upd[7:0]};
        if (clr_i) begin
            st_d = '0;
        end else if (en_i) begin
            if (st_q.cnt == LAST_ADDR) begin
                done_o = 1'b1;
                st_d   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.lp  = lp_upd;
                st_d.col = col_upd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0 && st_q.lp == '0 && st_q.col == '0));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(st_q));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && st_q.cnt == LAST_ADDR) |=> (st_q.cnt == '0));

endmodule

// File: rtl/nand_ecc_bank.sv
module nand_ecc_bank
    import nand_ecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              rd_mode_i,
    input  logic              rd_step_i,
    output logic              full_o,
    output logic [7:0]        byte_o
);

    localparam int IDX_W = $clog2(NUM_CHUNKS);
    localparam logic [IDX_W:0] END_IDX = (IDX_W+1)'(NUM_CHUNKS);

    typedef struct packed {
        logic [NUM_CHUNKS-1:0][CODE_W-1:0] slot;
        logic [IDX_W:0]                    wr_idx;
        logic [IDX_W:0]                    rd_chunk;
        logic [1:0]                        rd_pos;
    } bank_s;

    bank_s st_d, st_q;
    logic [CODE_W-1:0] cur;

    always_comb begin
        st_d   = st_q;
        full_o = (st_q.wr_idx == END_IDX);
        if (clr_i) begin
            st_d.slot   = '1;
            st_d.wr_idx = '0;
        end else if (wr_i && !full_o) begin
            st_d.slot[st_q.wr_idx[IDX_W-1:0]] = code_i;
            st_d.wr_idx = st_q.wr_idx + 1'b1;
        end
        if (!rd_mode_i) begin
            st_d.rd_chunk = '0;
            st_d.rd_pos   = '0;
        end else if (rd_step_i && st_q.rd_chunk != END_IDX) begin
            if (st_q.rd_pos == 2'd2) begin
                st_d.rd_pos   = '0;
                st_d.rd_chunk = st_q.rd_chunk + 1'b1;
            end else begin
                st_d.rd_pos = st_q.rd_pos + 1'b1;
            end
        end
        cur = st_q.slot[st_q.rd_chunk[IDX_W-1:0]];
        if (st_q.rd_chunk == END_IDX) begin
            byte_o = 8'hFF;
        end else begin
            case (st_q.rd_pos)
                2'd0:    byte_o = cur[15:8];
                2'd1:    byte_o = cur[7:0];
                default: byte_o = cur[23:16];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot     <= '1;
            st_q.wr_idx   <= '0;
            st_q.rd_chunk <= '0;
            st_q.rd_pos   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (rst_n) assert (st_q.rd_pos != 2'd3);
    end

    p_slot_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i && st_q.wr_idx != END_IDX)
            |=> (st_q.wr_idx == (IDX_W+1)'($past(st_q.wr_idx) + 1'b1)));

    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_idx == END_IDX && !clr_i) |=> (st_q.wr_idx == END_IDX));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mode_i |=> (st_q.rd_chunk == '0 && st_q.rd_pos == '0));

    p_read_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode_i && st_q.rd_chunk == END_IDX) |=> (st_q.rd_chunk == END_IDX));

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ecc_mode_i,
    input  logic       xfer_valid_i,
    input  logic [7:0] xfer_data_i,
    input  logic       rd_strobe_i,
    output logic [7:0] ecc_byte_o
);

    ecc_mode_e         mode;
    logic              clr, acc_en, rd_mode, full, done;
    logic [CODE_W-1:0] code;
    logic [7:0]        rd_byte;

    always_comb begin
        mode    = ecc_mode_e'(ecc_mode_i);
        clr     = (mode == ECC_CLEAR);
        rd_mode = (mode == ECC_READ);
        acc_en  = (mode == ECC_ACC) && xfer_valid_i && !full;
        ecc_byte_o = rd_mode ? rd_byte : 8'h00;
    end

    nand_ecc_chunk u_chunk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (acc_en),
        .data_i (xfer_data_i),
        .done_o (done),
        .code_o (code)
    );

    nand_ecc_bank #(.NUM_CHUNKS(NUM_CHUNKS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .wr_i      (done),
        .code_i    (code),
        .rd_mode_i (rd_mode),
        .rd_step_i (rd_strobe_i),
        .full_o    (full),
        .byte_o    (rd_byte)
    );

    p_no_store_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !done);

endmodule

// File: tb/nand_ecc_acc_tb.sv
module nand_ecc_acc_tb;

    localparam int NCH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       xv = 1'b0;
    logic [7:0] xd = 8'h00;
    logic       rs = 1'b0;
    logic [7:0] eb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  chunk_m [256];
    logic [23:0] exp_slot [NCH];
    int          exp_idx;

    always #4 clk = ~clk;

    nand_ecc_acc #(.NUM_CHUNKS(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ecc_mode_i(mode), .xfer_valid_i(xv),
        .xfer_data_i(xd), .rd_strobe_i(rs), .ecc_byte_o(eb)
    );

    function automatic logic [23:0] ref_code(input logic [7:0] b [256]);
        logic [15:0] lp = '0;
        logic [7:0]  c = '0;
        logic [5:0]  cp;
        for (int i = 0; i < 256; i++) begin
            logic p = ^b[i];
            c = c ^ b[i];
            for (int k = 0; k < 8; k++)
                if ((i >> k) & 1) lp[2*k+1] ^= p; else lp[2*k] ^= p;
        end
        cp[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
        cp[1] = c[1] ^ c[3] ^ c[5] ^ c[7];
        cp[2] = c[0] ^ c[1] ^ c[4] ^ c[5];
        cp[3] = c[2] ^ c[3] ^ c[6] ^ c[7];
        cp[4] = c[0] ^ c[1] ^ c[2] ^ c[3];
        cp[5] = c[4] ^ c[5] ^ c[6] ^ c[7];
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        xv = 1'b1;
        xd = b;
    endtask

    task automatic idle();
        @(negedge clk);
        xv = 1'b0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < NCH; i++) exp_slot[i] = 24'hFFFFFF;
        exp_idx = 0;
    endtask

    task automatic start_page();
        set_mode(2'b11);
        clear_model();
        set_mode(2'b00);
        set_mode(2'b01);
    endtask

    // sends chunk_m, updates model (R4, R10)
    task automatic send_chunk();
        for (int i = 0; i < 256; i++) send_byte(chunk_m[i]);
        idle();
        if (exp_idx < NCH) begin
            exp_slot[exp_idx] = ref_code(chunk_m);
            exp_idx++;
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) chunk_m[i] = 8'($urandom);
    endtask

    task automatic fill_single(input int addr, input int bitpos);
        for (int i = 0; i < 256; i++) chunk_m[i] = 8'h00;
        chunk_m[addr] = 8'(1 << bitpos);
    endtask

    // R8 order, R9 tail, R5/R6/R7 contents
    task automatic read_all(input string req);
        set_mode(2'b10);
        for (int j = 0; j < 3 * NCH + 3; j++) begin
            logic [7:0] e;
            int ch = j / 3;
            int ps = j % 3;
            if (ch >= NCH) e = 8'hFF;
            else if (ps == 0) e = exp_slot[ch][15:8];
            else if (ps == 1) e = exp_slot[ch][7:0];
            else e = exp_slot[ch][23:16];
            @(negedge clk);
            #1;
            check(eb, e, req);
            rs = 1'b1;
            @(negedge clk);
            rs = 1'b0;
        end
        set_mode(2'b00);
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(eb, 8'h00, "R1 idle output");
        read_all("R2/R9 reset contents");

        // R7 erased, R3 ignored bytes, R5/R6 single bits
        start_page();
        for (int i = 0; i < 256; i++) chunk_m[i] = 8'hFF;
        send_chunk();
        set_mode(2'b00);
        for (int i = 0; i < 40; i++) send_byte(8'($urandom));
        idle();
        set_mode(2'b01);
        fill_random();
        send_chunk();
        set_mode(2'b10);
        for (int i = 0; i < 17; i++) send_byte(8'($urandom));
        idle();
        set_mode(2'b00);
        @(negedge clk);
        #1;
        check(eb, 8'h00, "R1 off output");
        set_mode(2'b01);
        fill_single(8'h37, 0);
        send_chunk();
        fill_single(8'hC8, 7);
        send_chunk();
        fill_single(8'h00, 3);
        send_chunk();
        fill_single(8'hFF, 4);
        send_chunk();
        set_mode(2'b00);
        read_all("R3/R5/R6/R7/R8 mixed page");

        // R10 overflow, R9, R8 restart
        start_page();
        for (int c = 0; c < NCH + 1; c++) begin
            fill_random();
            send_chunk();
        end
        set_mode(2'b00);
        read_all("R10 full page");
        read_all("R8 re-entry restart");

        // R2 clear mid-chunk, R4 partial chunk not stored
        start_page();
        for (int i = 0; i < 100; i++) send_byte(8'($urandom));
        idle();
        start_page();
        fill_random();
        send_chunk();
        for (int i = 0; i < 50; i++) send_byte(8'($urandom));
        idle();
        set_mode(2'b00);
        read_all("R2/R4 clear and partial");

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule